// File: doc/BRIEF.md
# Multi-Mode Line Scaler

This block resamples one video line to a chosen output width. Source pixels arrive on a ready/valid stream, and the final pixel of the line is flagged. The block holds the line in a local buffer. It then generates the requested number of output pixels on a second ready/valid stream and flags the last one. The position of each output pixel in the source line is kept in 16.16 fixed point. This position starts at zero and grows by a programmable step, which is the input/output size ratio. The block offers three interpolation modes:

- copy of the preceding source pixel;
- two-pixel linear blend;
- four-tap filter whose weights are chosen per phase from a table that can be loaded at run time.

A small state machine controls the work. It starts in LOAD and accepts pixels there. When the flagged pixel is taken it moves to EMIT and computes one output per free slot in the output register. When the final output enters the register it moves to DRAIN and waits there until that output is taken. It then returns to LOAD for the next line. The mode, step and width must be held steady for the whole of a line.

Top module: `line_scaler`

## Requirements
- R1: While reset is held, and on the first cycle after reset, `m_valid` is 0 and `s_ready` is 1.
- R2: With `cfg_mode`=0 (copy), the output pixel k equals source pixel i, where pos = k·`cfg_step` (kept to 32 bits) and i = pos[31:16].
- R3: With `cfg_mode`=1 (linear), the output equals (a·(256−f) + b·f + 128) >> 8. Here a is source pixel i, b is source pixel i+1, and f = pos[15:8].
- R4: With `cfg_mode`=2 or 3 (four-tap), the output is the sum over j = 0..3 of coef[p][j] · source pixel (i+j−1), where p = pos[15:12] and the weights are signed with 8 fraction bits.
- R5: A tap index below 0 uses source pixel 0. A tap index beyond the last source pixel n−1 uses pixel n−1.
- R6: The four-tap sum has 128 added, is shifted right arithmetically by 8, and is clamped to the range 0..255.
- R7: Each line yields exactly `cfg_out_w` output pixels (at least 1). `m_last` is 1 on the final output only.
- R8: The source position starts at 0 for each line and grows by `cfg_step` per output pixel.
- R9: `s_ready` goes low on the cycle after the flagged input pixel is taken. It stays low until the final output has been taken, and is never high while `m_valid` is 1.
- R10: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data` and `m_last` hold their values.
- R11: A write with `cw_en` high stores `cw_data` as weight `cw_tap` of phase `cw_phase`. Reset loads weight 1 with 256−16p, weight 2 with 16p, and weights 0 and 3 with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | 0 copy, 1 linear, 2/3 four-tap |
| cfg_step | input | 32 | Source advance per output, 16.16 |
| cfg_out_w | input | 16 | Output pixels per line |
| cw_en | input | 1 | Weight write strobe |
| cw_phase | input | 4 | Phase to write |
| cw_tap | input | 2 | Tap to write |
| cw_data | input | 10 | Signed weight value |
| s_valid | input | 1 | Source pixel valid |
| s_ready | output | 1 | Source pixel accepted |
| s_data | input | 8 | Source pixel |
| s_last | input | 1 | Final pixel of the line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Output pixel taken |
| m_data | output | 8 | Output pixel |
| m_last | output | 1 | Final output of the line |

## Verification
The hardest case to reach is a four-tap result that falls outside 0..255 while its outer taps are replicated edge pixels. This needs three things at once:

- negative weights;
- a source line whose values change sharply between neighbours;
- positions that run past the ends of the line.

To get there, the bench loads a weight table with negative outer taps. It feeds lines that alternate between 0 and 255. It then requests more outputs than the step can cover, so the last outputs reach beyond the final source pixel. Output back-pressure is applied in an irregular pattern throughout, so outputs are often held.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    localparam int FRAC_W  = 8;
    localparam int TAPS    = 4;
    localparam int POS_W   = 32;
    localparam int CTR_W   = 16;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_DRAIN = 2'd2
    } lsc_state_e;

    typedef enum logic [1:0] {
        MD_COPY   = 2'd0,
        MD_LINEAR = 2'd1,
        MD_POLY   = 2'd2,
        MD_POLY_B = 2'd3
    } lsc_mode_e;
endpackage

// File: rtl/lsc_linebuf.sv
module lsc_linebuf #(
    parameter int PIX_W  = 8,
    parameter int DEPTH  = 64,
    parameter int CTR_W  = 16,
    parameter int TAPS   = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int IX_W  = CTR_W + 2
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [PIX_W-1:0] wr_data,
    input  logic [CTR_W-1:0] center,
    input  logic [CW-1:0]    n_src,
    output logic [PIX_W-1:0] rd [TAPS]
);
    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    logic signed [IX_W-1:0] top_ix;
    assign top_ix = $signed(IX_W'(n_src)) - IX_W'(1);

    // Tap t reads source index center+t-1, replicated at both line ends.
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        localparam int OFF = t - 1;
        logic signed [IX_W-1:0] ix;
        logic signed [IX_W-1:0] cl;
        always_comb begin
            ix = $signed(IX_W'(center)) + IX_W'(OFF);
            if (ix < 0)           cl = '0;
            else if (ix > top_ix) cl = top_ix;
            else                  cl = ix;
        end
        assign rd[t] = mem[AW'(cl)];
    end
endmodule

// File: rtl/lsc_coef.sv
module lsc_coef #(
    parameter int COEF_W = 10,
    parameter int PHASES = 16,
    parameter int TAPS   = 4,
    parameter int FRAC_W = 8,
    localparam int PH_W  = $clog2(PHASES),
    localparam int TP_W  = $clog2(TAPS),
    localparam int ONE   = 1 << FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [PH_W-1:0]          wphase,
    input  logic [TP_W-1:0]          wtap,
    input  logic signed [COEF_W-1:0] wdata,
    input  logic [PH_W-1:0]          rphase,
    output logic signed [COEF_W-1:0] rd [TAPS]
);
    logic signed [COEF_W-1:0] tbl [PHASES][TAPS];

    function automatic logic signed [COEF_W-1:0] preset(int p, int t);
        int w;
        w = (ONE * p) / PHASES;
        if (t == 1) return COEF_W'(ONE - w);
        if (t == 2) return COEF_W'(w);
        return '0;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < PHASES; p++)
                for (int t = 0; t < TAPS; t++)
                    tbl[p][t] <= preset(p, t);
        end else if (we) begin
            tbl[wphase][wtap] <= wdata;
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_rd
        assign rd[t] = tbl[rphase][t];
    end
endmodule

// File: rtl/lsc_kernel.sv
module lsc_kernel
    import lsc_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 10,
    localparam int ACC_W = PIX_W + COEF_W + 3,
    localparam int LW    = PIX_W + FRAC_W + 2,
    localparam int ONE   = 1 << FRAC_W,
    localparam int HALF  = 1 << (FRAC_W - 1),
    localparam int MAXP  = (1 << PIX_W) - 1
) (
    input  logic [1:0]               mode,
    input  logic [FRAC_W-1:0]        frac,
    input  logic [PIX_W-1:0]         px [TAPS],
    input  logic signed [COEF_W-1:0] cf [TAPS],
    output logic [PIX_W-1:0]         result
);
    logic signed [ACC_W-1:0] acc, rnd;
    logic [PIX_W-1:0]        poly_px;
    logic [LW-1:0]           lsum;

    always_comb begin
        acc = '0;
        for (int t = 0; t < TAPS; t++)
            acc = acc + $signed({{(ACC_W-PIX_W){1'b0}}, px[t]}) * ACC_W'(cf[t]);
        rnd = (acc + ACC_W'(HALF)) >>> FRAC_W;
        if (rnd < 0)                 poly_px = '0;
        else if (rnd > ACC_W'(MAXP)) poly_px = PIX_W'(MAXP);
        else                         poly_px = PIX_W'(rnd);
    end

    assign lsum = LW'(px[1]) * LW'(ONE - int'(frac))
                + LW'(px[2]) * LW'(frac) + LW'(HALF);

    always_comb begin
        unique case (lsc_mode_e'(mode))
            MD_COPY:   result = px[1];
            MD_LINEAR: result = PIX_W'(lsum >> FRAC_W);
            default:   result = poly_px;
        endcase
    end
endmodule

// File: rtl/line_scaler.sv
module line_scaler
    import lsc_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int LINE_MAX = 64,
    parameter int COEF_W   = 10,
    parameter int PHASES   = 16,
    localparam int AW      = $clog2(LINE_MAX),
    localparam int CW      = AW + 1,
    localparam int PH_W    = $clog2(PHASES),
    localparam int TP_W    = $clog2(TAPS),
    localparam int FB      = POS_W - CTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [POS_W-1:0]  cfg_step,
    input  logic [CTR_W-1:0]  cfg_out_w,
    input  logic              cw_en,
    input  logic [PH_W-1:0]   cw_phase,
    input  logic [TP_W-1:0]   cw_tap,
    input  logic [COEF_W-1:0] cw_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [PIX_W-1:0]  s_data,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [PIX_W-1:0]  m_data,
    output logic              m_last
);
    lsc_state_e st, st_nx;

    logic [AW-1:0]            cnt;
    logic [CW-1:0]            nsrc;
    logic [POS_W-1:0]         pos;
    logic [CTR_W-1:0]         k;
    logic                     take_in, load_out, last_out;
    logic [PIX_W-1:0]         win [TAPS];
    logic signed [COEF_W-1:0] wts [TAPS];
    logic [PIX_W-1:0]         kern_px;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_LOAD;
        else        st <= st_nx;
    end

    // Next state and handshake outputs
    always_comb begin
        st_nx    = st;
        s_ready  = 1'b0;
        load_out = 1'b0;
        last_out = (k == cfg_out_w - CTR_W'(1));
        unique case (st)
            ST_LOAD: begin
                s_ready = 1'b1;
                if (s_valid && s_last) st_nx = ST_EMIT;
            end
            ST_EMIT: begin
                load_out = !m_valid || m_ready;
                if (load_out && last_out) st_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (m_ready) st_nx = ST_LOAD;
            end
            default: st_nx = ST_LOAD;
        endcase
    end

    assign take_in = s_ready && s_valid;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            nsrc    <= CW'(1);
            pos     <= '0;
            k       <= '0;
            m_valid <= 1'b0;
            m_data  <= '0;
            m_last  <= 1'b0;
        end else begin
            if (take_in) begin
                if (s_last) begin
                    nsrc <= CW'(cnt) + CW'(1);
                    cnt  <= '0;
                    pos  <= '0;
                    k    <= '0;
                end else if (cnt != AW'(LINE_MAX - 1)) begin
                    cnt <= cnt + AW'(1);
                end
            end
            if (load_out) begin
                m_valid <= 1'b1;
                m_data  <= kern_px;
                m_last  <= last_out;
                pos     <= pos + cfg_step;
                k       <= k + CTR_W'(1);
            end else if (m_ready) begin
                m_valid <= 1'b0;
            end
        end
    end

    lsc_linebuf #(
        .PIX_W(PIX_W), .DEPTH(LINE_MAX), .CTR_W(CTR_W), .TAPS(TAPS)
    ) u_buf (
        .clk     (clk),
        .wr_en   (take_in),
        .wr_addr (cnt),
        .wr_data (s_data),
        .center  (pos[POS_W-1:FB]),
        .n_src   (nsrc),
        .rd      (win)
    );

    lsc_coef #(
        .COEF_W(COEF_W), .PHASES(PHASES), .TAPS(TAPS), .FRAC_W(FRAC_W)
    ) u_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cw_en),
        .wphase (cw_phase),
        .wtap   (cw_tap),
        .wdata  ($signed(cw_data)),
        .rphase (pos[FB-1 -: PH_W]),
        .rd     (wts)
    );

    lsc_kernel #(
        .PIX_W(PIX_W), .COEF_W(COEF_W)
    ) u_kern (
        .mode   (cfg_mode),
        .frac   (pos[FB-1 -: FRAC_W]),
        .px     (win),
        .cf     (wts),
        .result (kern_px)
    );
endmodule

// File: rtl/lsc_props.sv
module lsc_props #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_valid,
    input logic             s_ready,
    input logic             s_last,
    input logic             m_valid,
    input logic             m_ready,
    input logic [PIX_W-1:0] m_data,
    input logic             m_last
);
    // R1: idle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!m_valid && s_ready));

    // R10: held output does not change
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    // R9: input closes after the flagged pixel
    a_r9_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last) |=> !s_ready);

    // R9: never accepting while an output is pending
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !s_ready);

    // R7: line end returns to accepting input
    a_r7_line_end_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> (!m_valid && s_ready));
endmodule

bind line_scaler lsc_props #(.PIX_W(PIX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_last  (s_last),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_last  (m_last)
);

// File: tb/sim_line_scaler.sv
`timescale 1ns/1ps
module sim_line_scaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [31:0] cfg_step = 32'h10000;
    logic [15:0] cfg_out_w = 16'd1;
    logic        cw_en = 1'b0;
    logic [3:0]  cw_phase = '0;
    logic [1:0]  cw_tap = '0;
    logic [9:0]  cw_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [7:0]  m_data;
    logic        m_last;

    int checks = 0;
    int failures = 0;
    int px [64];
    int cb [16][4];

    always #2.5 clk = ~clk;

    line_scaler u0 (.*);

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // Expected pixel from R2..R6 and R8
    function automatic int exp_px(int md, longint stp, int k, int n);
        longint pos;
        int i, f, p, s;
        int a [4];
        pos = (longint'(k) * stp) & 64'hFFFF_FFFF;
        i = int'(pos >> 16);
        f = int'((pos >> 8) & 255);
        p = int'((pos >> 12) & 15);
        for (int t = 0; t < 4; t++) a[t] = px[clampi(i + t - 1, 0, n - 1)];
        if (md == 0) return a[1];
        if (md == 1) return (a[1] * (256 - f) + a[2] * f + 128) >> 8;
        s = 0;
        for (int t = 0; t < 4; t++) s += a[t] * cb[p][t];
        return clampi((s + 128) >>> 8, 0, 255);
    endfunction

    task automatic wr_coef(int p, int t, int v);
        @(negedge clk);
        cw_en = 1'b1; cw_phase = 4'(p); cw_tap = 2'(t); cw_data = 10'(v);
        cb[p][t] = v;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    task automatic run_line(int md, longint stp, int w, int n, string tag);
        @(negedge clk);
        cfg_mode = 2'(md); cfg_step = 32'(stp); cfg_out_w = 16'(w);
        fork
            begin
                int idx = 0;
                int g = 0;
                while (idx < n) begin
                    @(negedge clk);
                    g++;
                    if ((g % 3) == 2) s_valid = 1'b0;
                    else begin
                        s_valid = 1'b1; s_data = 8'(px[idx]); s_last = (idx == n - 1);
                        if (s_ready) idx++;
                    end
                end
                @(negedge clk);
                s_valid = 1'b0; s_last = 1'b0;
            end
            begin
                int got = 0;
                int cyc = 0;
                bit hold = 0;
                int hd = 0;
                bit hl = 0;
                while (got < w) begin
                    @(negedge clk);
                    cyc++;
                    if (hold) chk(m_valid && int'(m_data) == hd && m_last == hl,
                                  "R10 held output", int'(m_data), hd);
                    if (m_valid) chk(!s_ready, "R9 input closed", int'(s_ready), 0);
                    m_ready = ((cyc * 3 + got) % 4) != 0;
                    if (m_valid && m_ready) begin
                        chk(int'(m_data) == exp_px(md, stp, got, n), tag,
                            int'(m_data), exp_px(md, stp, got, n));
                        chk(m_last == (got == w - 1), "R7 last flag",
                            int'(m_last), int'(got == w - 1));
                        got++;
                        hold = 0;
                    end else begin
                        hold = m_valid; hd = int'(m_data); hl = m_last;
                    end
                end
            end
        join
        @(negedge clk);
        m_ready = 1'b0;
        chk(s_ready && !m_valid, "R7 R9 line closed", int'(m_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        longint steps [6] = '{32'h10000, 32'h8000, 32'h20000, 32'hC000, 32'h18000, 32'h5555};
        int lens [3] = '{1, 5, 13};
        string tg;
        for (int p = 0; p < 16; p++)
            for (int t = 0; t < 4; t++)
                cb[p][t] = (t == 1) ? 256 - 16 * p : ((t == 2) ? 16 * p : 0);
        repeat (3) @(negedge clk);
        chk(!m_valid && s_ready, "R1 in reset", int'(m_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!m_valid && s_ready, "R1 after reset", int'(s_ready), 1);

        // Sweep modes, steps and line lengths with the preset table (R2 R3 R4 R5 R8 R11)
        for (int md = 0; md < 3; md++)
            for (int si = 0; si < 6; si++)
                for (int li = 0; li < 3; li++) begin
                    int n = lens[li];
                    int w = clampi(int'((longint'(n) * 65536 + steps[si] - 1) / steps[si]), 1, 40);
                    for (int j = 0; j < n; j++) px[j] = (j * 37 + md * 11 + si * 5) & 255;
                    tg = (md == 0) ? "R2 R8 copy" : ((md == 1) ? "R3 R8 linear" : "R4 R11 preset");
                    run_line(md, steps[si], w + (li == 2 ? 3 : 0), n, tg);
                end

        // Overshooting weights: t0=-32, t1=288-16p, t2=16p+32, t3=-32 (R6 R11)
        for (int p = 0; p < 16; p++) begin
            wr_coef(p, 0, -32);
            wr_coef(p, 1, 288 - 16 * p);
            wr_coef(p, 2, 16 * p + 32);
            wr_coef(p, 3, -32);
        end
        for (int si = 0; si < 6; si++) begin
            int n = 9;
            for (int j = 0; j < n; j++) px[j] = ((j / (si % 2 + 1)) % 2) ? 255 : 0;
            px[n - 1] = 255;
            // R5 edge replication: width runs past the line end
            run_line((si == 5) ? 3 : 2, steps[si], 24, n, "R4 R5 R6 R11 custom");
        end
        // Ramp with custom weights, mid-range values
        for (int j = 0; j < 20; j++) px[j] = 40 + j * 9;
        run_line(2, 32'h6000, 50, 20, "R4 R6 ramp");
        run_line(1, 32'h3000, 60, 20, "R3 R8 fine step");
        summary();
    end
endmodule